// File: doc/BRIEF.md
# Bus Access Order Protection Unit

This unit sits between a pipelined CPU's separate write and read request ports and a single shared memory bus. A write is taken into a one-entry pending slot and issued to the bus later, so a younger read that comes right behind it can reach the bus first. That is the fast path for ordinary memory. For peripheral frames it is wrong, because a read can depend on the side effect of the write before it.

The unit compares each read address against a set of fixed address windows. Each window has its own enable bit, and every bit is set after reset. If a read falls in an enabled window while an older write is still pending or still being offered, the unit holds the read and raises a stall. The older write then goes to the bus first, and the read follows. If the read targets the same address as that older write, the same ordering applies whatever the window settings are. Any other read overtakes the pending write with no stall. The bus side is a single request/grant port: a transfer happens in each cycle where the request and the grant are both high.

Top module: `bus_order_guard`

## Requirements
- R1: After reset the bus request is low, stall is low, the write port is ready, and every zone enable bit reads 1.
- R2: A read whose address is in no enabled zone and differs from the older write's address goes to the bus before that pending write, with stall low.
- R3: A read inside an enabled zone, issued after a write that is still pending, raises stall. The bus then carries the write first and the read after it.
- R4: A read to the same address as the pending write is always ordered behind that write, even when the address lies outside every zone.
- R5: Stall stays high in every cycle from the cycle the conflicting read appears up to and including the cycle the bus grants the older write. It is low in the following cycle, when the read is granted.
- R6: A pulse on the configuration strobe loads the zone enable bits (bit i controls zone i). A disabled zone behaves as unprotected. Zone bounds are inclusive: by default zone 0 is 0x6000..0x6FFF, zone 1 is 0x7000..0x7FFF and zone 2 is 0x4000..0x4FFF.
- R7: The write port is ready when the pending slot is empty, or when the slot's write is granted in the same cycle. This lets writes stream one per cycle.
- R8: A write being offered in the same cycle as a read counts as older. A protected read stalls behind it, while an unprotected read to another address goes first.
- R9: On the bus, busWrite=1 carries the pending write's address and data, and busWrite=0 carries the read address. Every access accepted from the CPU appears on the bus exactly once.
- R10: While the bus withholds the grant, the pending write stays pending and a read stalled behind it stays stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | CPU write request |
| wrAddr | input | ADDR_W | CPU write address |
| wrData | input | DATA_W | CPU write data |
| wrReady | output | 1 | Write taken into the pending slot |
| rdValid | input | 1 | CPU read request, held until rdReady |
| rdAddr | input | ADDR_W | CPU read address |
| rdReady | output | 1 | Read granted on the bus this cycle |
| cfgWe | input | 1 | Load strobe for the zone enable bits |
| cfgEn | input | NUM_ZONES | New zone enable bits |
| zoneEn | output | NUM_ZONES | Current zone enable bits |
| stall | output | 1 | Read held behind an older write |
| busReq | output | 1 | Bus request |
| busWrite | output | 1 | 1 for a write transfer, 0 for a read transfer |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | DATA_W | Bus write data |
| busGnt | input | 1 | Bus grant; a transfer occurs when busReq and busGnt are both high |

## Verification
The interesting collision is a new write being offered in the same cycle as a read, which may also be the cycle the bus drains the previous write. Both the ordering decision and the pending-slot refill then happen at once. The bench drives write and read together, both into a protected zone and outside it, and streams writes back to back. It judges the outcome by popping each bus transfer against an expected program-order queue and by sampling stall and the ready signals in every cycle of the overlap.

// File: rtl/bog_pkg.sv
package bog_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic issueRead;  // bus carries the read this cycle
    logic capture;    // load the incoming write into the pending slot
  } bogStrobe_t;
endpackage

// File: rtl/bog_datapath.sv
module bog_datapath
  import bog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int NUM_ZONES = 3,
  parameter logic [NUM_ZONES*ADDR_W-1:0] ZONE_LO = '0,
  parameter logic [NUM_ZONES*ADDR_W-1:0] ZONE_HI = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic                 cfgWe,
  input  logic [NUM_ZONES-1:0] cfgEn,
  input  bogStrobe_t           strobe,
  output logic [NUM_ZONES-1:0] zoneEn,
  output logic                 rdProt,
  output logic                 hitPend,
  output logic                 hitIn,
  output logic [ADDR_W-1:0]    pendAddr,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [DATA_W-1:0]    busWdata
);
  logic [DATA_W-1:0]    pendData;
  logic [NUM_ZONES-1:0] inZone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zoneEn <= '1;
    end else if (cfgWe) begin
      zoneEn <= cfgEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr <= '0;
      pendData <= '0;
    end else if (strobe.capture) begin
      pendAddr <= wrAddr;
      pendData <= wrData;
    end
  end

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    localparam logic [ADDR_W-1:0] LO = ZONE_LO[z*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] HI = ZONE_HI[z*ADDR_W +: ADDR_W];
    assign inZone[z] = (rdAddr >= LO) && (rdAddr <= HI);
  end

  assign rdProt   = |(inZone & zoneEn);
  assign hitPend  = (rdAddr == pendAddr);
  assign hitIn    = (rdAddr == wrAddr);
  assign busAddr  = strobe.issueRead ? rdAddr : pendAddr;
  assign busWdata = pendData;
endmodule

// File: rtl/bog_control.sv
module bog_control
  import bog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       rdValid,
  input  logic       busGnt,
  input  logic       rdProt,
  input  logic       hitPend,
  input  logic       hitIn,
  output bogStrobe_t strobe,
  output logic       pendValid,
  output logic       stall,
  output logic       wrReady,
  output logic       rdReady,
  output logic       busReq,
  output logic       busWrite
);
  logic conflict, selRead, wrGrant, accept;

  // an offered write is older than a read in the same cycle
  assign conflict = rdValid &&
                    ((pendValid && (rdProt || hitPend)) ||
                     (wrValid   && (rdProt || hitIn)));
  assign selRead  = rdValid && !conflict;
  assign busReq   = selRead || pendValid;
  assign busWrite = pendValid && !selRead;
  assign wrGrant  = busWrite && busGnt;
  assign wrReady  = !pendValid || wrGrant;
  assign accept   = wrValid && wrReady;
  assign rdReady  = selRead && busGnt;
  assign stall    = conflict;

  assign strobe.issueRead = selRead;
  assign strobe.capture   = accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
    end else if (accept) begin
      pendValid <= 1'b1;
    end else if (wrGrant) begin
      pendValid <= 1'b0;
    end
  end

  // R10: an ungranted pending write is kept
  assert_write_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !(busReq && busGnt && busWrite)) |=> pendValid);
endmodule

// File: rtl/bus_order_guard.sv
module bus_order_guard
  import bog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int NUM_ZONES = 3,
  parameter logic [NUM_ZONES*ADDR_W-1:0] ZONE_LO = {16'h4000, 16'h7000, 16'h6000},
  parameter logic [NUM_ZONES*ADDR_W-1:0] ZONE_HI = {16'h4FFF, 16'h7FFF, 16'h6FFF}
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrValid,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  output logic                 wrReady,
  input  logic                 rdValid,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic                 rdReady,
  input  logic                 cfgWe,
  input  logic [NUM_ZONES-1:0] cfgEn,
  output logic [NUM_ZONES-1:0] zoneEn,
  output logic                 stall,
  output logic                 busReq,
  output logic                 busWrite,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [DATA_W-1:0]    busWdata,
  input  logic                 busGnt
);
  bogStrobe_t        strobe;
  logic              pendValid, rdProt, hitPend, hitIn;
  logic [ADDR_W-1:0] pendAddr;

  bog_control u_control (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdValid(rdValid),
    .busGnt(busGnt), .rdProt(rdProt), .hitPend(hitPend), .hitIn(hitIn),
    .strobe(strobe), .pendValid(pendValid), .stall(stall),
    .wrReady(wrReady), .rdReady(rdReady), .busReq(busReq), .busWrite(busWrite)
  );

  bog_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ZONES(NUM_ZONES),
    .ZONE_LO(ZONE_LO), .ZONE_HI(ZONE_HI)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .cfgWe(cfgWe), .cfgEn(cfgEn), .strobe(strobe),
    .zoneEn(zoneEn), .rdProt(rdProt), .hitPend(hitPend), .hitIn(hitIn),
    .pendAddr(pendAddr), .busAddr(busAddr), .busWdata(busWdata)
  );

  // R3: no protected read is granted while an older write waits
  assert_prot_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt && !busWrite && rdProt) |-> (!pendValid && !wrValid));

  // R4: a read never passes a pending write to its own address
  assert_same_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt && !busWrite) |-> !(pendValid && busAddr == pendAddr));

  // R5: stall only ends after the write grant (or a zone reload)
  assert_stall_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> ($past(busReq && busGnt && busWrite) || $past(cfgWe) || !rdValid));

  // R8: an offered write holds back a protected read in the same cycle
  assert_incoming_older_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && wrValid && rdProt) |-> (stall && !rdReady));
endmodule

// File: tb/bus_order_guard_bench.sv
module bus_order_guard_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0, rdValid = 1'b0, cfgWe = 1'b0, busGnt = 1'b1;
  logic [15:0] wrAddr = '0, wrData = '0, rdAddr = '0;
  logic [2:0]  cfgEn = '0;
  logic        wrReady, rdReady, stall, busReq, busWrite;
  logic [2:0]  zoneEn;
  logic [15:0] busAddr, busWdata;

  int checks = 0;
  int fails = 0;
  logic [32:0] expQ[$];

  always #2 clk = ~clk;

  bus_order_guard u_bus_order_guard (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrReady(wrReady), .rdValid(rdValid), .rdAddr(rdAddr), .rdReady(rdReady),
    .cfgWe(cfgWe), .cfgEn(cfgEn), .zoneEn(zoneEn), .stall(stall),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busGnt(busGnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expectBus(input logic w, input logic [15:0] a, input logic [15:0] d);
    expQ.push_back({w, a, d});
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: each bus transfer against program order (R9)
  always @(negedge clk) begin
    if (rstN && busReq && busGnt) begin
      if (expQ.size() == 0) begin
        chk("R9 unexpected transfer", {15'd0, busWrite, busAddr}, 32'hFFFF_FFFF);
      end else begin
        logic [32:0] e;
        e = expQ.pop_front();
        chk("R9 bus kind/addr", {15'd0, busWrite, busAddr}, {15'd0, e[32], e[31:16]});
        if (e[32]) chk("R9 write data", {16'd0, busWdata}, {16'd0, e[15:0]});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    finishRun();
  end

  // write in cycle 0, read in cycle 1
  task automatic wrThenRd(input logic [15:0] wa, input logic [15:0] ra, input logic ordered,
                          input string req);
    if (ordered) begin
      expectBus(1'b1, wa, wa ^ 16'h5A5A);
      expectBus(1'b0, ra, 16'h0);
    end else begin
      expectBus(1'b0, ra, 16'h0);
      expectBus(1'b1, wa, wa ^ 16'h5A5A);
    end
    wrValid = 1'b1; wrAddr = wa; wrData = wa ^ 16'h5A5A;
    tick();
    wrValid = 1'b0; rdValid = 1'b1; rdAddr = ra;
    @(negedge clk);
    chk({req, " stall"}, {31'd0, stall}, {31'd0, ordered});
    chk({req, " rdReady"}, {31'd0, rdReady}, {31'd0, !ordered});
    if (ordered) begin
      tick();
      @(negedge clk);
      chk({req, " stall released"}, {31'd0, stall}, 32'd0);
      chk({req, " read granted"}, {31'd0, rdReady}, 32'd1);
    end
    tick();
    rdValid = 1'b0;
    repeat (3) tick();
  endtask

  initial begin
    #1;
    @(negedge clk);
    chk("R1 busReq in reset", {31'd0, busReq}, 32'd0);
    repeat (2) tick();
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busReq", {31'd0, busReq}, 32'd0);
    chk("R1 stall", {31'd0, stall}, 32'd0);
    chk("R1 wrReady", {31'd0, wrReady}, 32'd1);
    chk("R1 zoneEn", {29'd0, zoneEn}, 32'd7);
    tick();

    wrThenRd(16'h1000, 16'h1004, 1'b0, "R2 unprotected bypass");
    wrThenRd(16'h6010, 16'h6020, 1'b1, "R3 protected zone0");
    wrThenRd(16'h1000, 16'h1000, 1'b1, "R4 same address");
    wrThenRd(16'h1000, 16'h6FFF, 1'b1, "R6 inclusive upper bound");
    wrThenRd(16'h1000, 16'h8000, 1'b0, "R6 just above zone1");

    // R6: disable zone 0
    cfgWe = 1'b1; cfgEn = 3'b110;
    tick();
    cfgWe = 1'b0;
    @(negedge clk);
    chk("R6 zoneEn loaded", {29'd0, zoneEn}, 32'd6);
    tick();
    wrThenRd(16'h6010, 16'h6020, 1'b0, "R6 disabled zone bypass");
    wrThenRd(16'h6010, 16'h6010, 1'b1, "R4 same address in disabled zone");
    cfgWe = 1'b1; cfgEn = 3'b111;
    tick();
    cfgWe = 1'b0;
    tick();

    // R10 / R5: grant withheld while a protected read waits
    expectBus(1'b1, 16'h2222, 16'hBEEF);
    expectBus(1'b0, 16'h7010, 16'h0);
    wrValid = 1'b1; wrAddr = 16'h2222; wrData = 16'hBEEF;
    tick();
    wrValid = 1'b0; rdValid = 1'b1; rdAddr = 16'h7010; busGnt = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 stall held", {31'd0, stall}, 32'd1);
      chk("R10 write still requested", {30'd0, busReq, busWrite}, 32'd3);
      tick();
    end
    busGnt = 1'b1;
    @(negedge clk);
    chk("R5 stall in grant cycle", {31'd0, stall}, 32'd1);
    tick();
    @(negedge clk);
    chk("R5 stall low after grant", {31'd0, stall}, 32'd0);
    chk("R5 read follows", {31'd0, rdReady}, 32'd1);
    tick();
    rdValid = 1'b0;
    repeat (3) tick();

    // R8: write and protected read in the same cycle
    expectBus(1'b1, 16'h1234, 16'h0F0F);
    expectBus(1'b0, 16'h4100, 16'h0);
    wrValid = 1'b1; wrAddr = 16'h1234; wrData = 16'h0F0F;
    rdValid = 1'b1; rdAddr = 16'h4100;
    @(negedge clk);
    chk("R8 protected read stalls behind offered write", {31'd0, stall}, 32'd1);
    tick();
    wrValid = 1'b0;
    @(negedge clk);
    chk("R8 stall while write drains", {31'd0, stall}, 32'd1);
    tick();
    @(negedge clk);
    chk("R8 read after write", {31'd0, rdReady}, 32'd1);
    tick();
    rdValid = 1'b0;
    repeat (3) tick();

    // R8: write and unprotected read in the same cycle
    expectBus(1'b0, 16'h2000, 16'h0);
    expectBus(1'b1, 16'h1234, 16'h3C3C);
    wrValid = 1'b1; wrAddr = 16'h1234; wrData = 16'h3C3C;
    rdValid = 1'b1; rdAddr = 16'h2000;
    @(negedge clk);
    chk("R8 unprotected read goes first", {30'd0, stall, rdReady}, 32'd1);
    tick();
    wrValid = 1'b0; rdValid = 1'b0;
    repeat (3) tick();

    // R7: streamed writes
    for (int i = 0; i < 3; i++) begin
      expectBus(1'b1, 16'h1100 + 16'(i), 16'hA000 + 16'(i));
    end
    for (int i = 0; i < 3; i++) begin
      wrValid = 1'b1; wrAddr = 16'h1100 + 16'(i); wrData = 16'hA000 + 16'(i);
      @(negedge clk);
      chk("R7 write ready each cycle", {31'd0, wrReady}, 32'd1);
      tick();
    end
    wrValid = 1'b0;
    repeat (4) tick();

    chk("R9 every access issued once", expQ.size(), 32'd0);
    finishRun();
  end
endmodule